// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block connects one processor to the interrupt distributor. Each cycle the distributor offers its best pending candidate: a valid flag, a 10-bit interrupt ID and an 8-bit priority, where a lower number means a more urgent interrupt. The interface decides whether that candidate may interrupt the processor. To qualify, signalling must be enabled, the ID must be a usable peripheral ID, and the priority must be strictly below two limits: the software priority mask and the current running priority. The request line to the processor follows that decision.

Software works through a small register bus. Reading the acknowledge register takes the qualified interrupt. The read returns the interrupt's ID, and the interface pushes the interrupt's priority onto an internal stack of active interrupts. The top of that stack becomes the new running priority, so only a more urgent interrupt can preempt the one being handled. The interface also sends the distributor a one-cycle pulse carrying the ID, so that the distributor can clear pending and set active.

Writing an ID to the end-of-interrupt register removes that interrupt from the stack and sends a matching completion pulse. The running priority falls back to the entry that is now on top of the stack, or to idle when the stack is empty. When nothing qualifies, the acknowledge register returns the spurious ID 1023.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset the request line is low, the control register reads 0, the priority mask reads 0x00 and the running priority reads 0xFF (idle).
- R2: A read of the acknowledge register while a candidate qualifies returns its ID in bits 9:0, with bits 31:10 zero. In the next cycle the running priority equals that candidate's priority, and act_set pulses for one cycle with act_set_id equal to the ID.
- R3: A candidate qualifies only if its priority is numerically below the priority mask. A priority equal to the mask is not signalled, and with a mask of 0xF0 a priority of 0xA0 is signalled.
- R4: While control bit 0 is clear, the request line stays low and an acknowledge read returns 1023 without changing the running priority.
- R5: A candidate qualifies only if its priority is numerically below the current running priority. A candidate with a priority equal to the running priority is neither signalled nor acknowledged.
- R6: An end-of-interrupt write with the ID of the most recent active interrupt sets the running priority back to the previous stacked priority, or to 0xFF when no active interrupt remains. act_clr pulses with that ID.
- R7: An end-of-interrupt write with an ID that is not active leaves the running priority unchanged and produces no act_clr pulse.
- R8: A candidate whose ID is above 1019 (IDs 1020 to 1023 are reserved), or whose valid flag is low, is never signalled. An acknowledge read returns 1023 in that case.
- R9: When STACK_DEPTH interrupts are already active, no further candidate is signalled or acknowledged, whatever its priority.
- R10: The request line is registered. It rises in the cycle after the candidate first qualifies, and falls in the cycle after it stops qualifying.
- R11: Register word addresses: 0 = control (bit 0 enable), 1 = priority mask (bits 7:0), 2 = acknowledge (read), 3 = end-of-interrupt (write, ID in bits 9:0), 4 = running priority (read), 5 = highest pending. A read of address 5 returns the ID that an acknowledge would return, and has no side effect.
- R12: An end-of-interrupt write with the ID of an active interrupt that is not the most recent one removes only that entry. The running priority stays unchanged, and act_clr pulses with that ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| bus_en | input | 1 | Register access strobe, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request to the processor |
| act_set | output | 1 | Pulse: interrupt acknowledged |
| act_set_id | output | 10 | ID of the acknowledged interrupt |
| act_clr | output | 1 | Pulse: interrupt completed |
| act_clr_id | output | 10 | ID of the completed interrupt |

## Verification
The qualification logic is driven with candidates placed on and next to each of its limits. One candidate has a priority equal to the mask and another is one step below it, which separates a strict compare from an inclusive one. One candidate has a priority equal to the running priority and another is more urgent, which shows whether preemption works. Reserved IDs, an invalid candidate and a disabled control bit each have to produce the spurious ID on their own.

Completion is tried with an ID that is not active, an ID that is active but not on top of the stack, and the top ID itself. These cases show whether the stack searches for and removes the right entry, and whether the running priority falls back only when the top entry goes. Filling the stack to its depth shows that a fully stacked interface refuses even the most urgent candidate.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ID_W-1:0]   ID_SPURIOUS   = 10'd1023;
    localparam logic [ID_W-1:0]   ID_LAST_USE   = 10'd1019;
    localparam logic [PRIO_W-1:0] PRIO_IDLE     = '1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_MASK = 3'd1,
        REG_ACK  = 3'd2,
        REG_EOI  = 3'd3,
        REG_RUN  = 3'd4,
        REG_PEND = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } irq_ent_t;

    function automatic logic id_usable(input logic [ID_W-1:0] id);
        return id <= ID_LAST_USE;
    endfunction

    function automatic logic [DATA_W-1:0] widen_id(input logic [ID_W-1:0] id);
        return {{(DATA_W-ID_W){1'b0}}, id};
    endfunction

endpackage

// File: rtl/cpu_irq_regs.sv
module cpu_irq_regs
    import cpu_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ctrl_en,
    output logic [PRIO_W-1:0] pmask,
    output logic              ack_rd,
    output logic              eoi_wr,
    output logic [ID_W-1:0]   eoi_id
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            pmask   <= '0;
        end else if (bus_en && bus_we) begin
            if (sel == REG_CTRL) ctrl_en <= bus_wdata[0];
            if (sel == REG_MASK) pmask   <= bus_wdata[PRIO_W-1:0];
        end
    end

    assign ack_rd = bus_en && !bus_we && (sel == REG_ACK);
    assign eoi_wr = bus_en &&  bus_we && (sel == REG_EOI);
    assign eoi_id = bus_wdata[ID_W-1:0];

endmodule

// File: rtl/cpu_irq_select.sv
module cpu_irq_select
    import cpu_irq_pkg::*;
(
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              ctrl_en,
    input  logic [PRIO_W-1:0] pmask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stk_full,
    output logic              qualify,
    output logic [ID_W-1:0]   sel_id
);

    logic below_mask, below_run;

    assign below_mask = cand_prio < pmask;
    assign below_run  = cand_prio < run_prio;

    assign qualify = ctrl_en && cand_valid && id_usable(cand_id)
                   && below_mask && below_run && !stk_full;
    assign sel_id  = qualify ? cand_id : ID_SPURIOUS;

endmodule

// File: rtl/cpu_irq_stack.sv
module cpu_irq_stack
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop_req,
    input  logic [ID_W-1:0]   pop_id,
    output logic [PRIO_W-1:0] run_prio,
    output logic              full,
    output logic              pop_hit
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    irq_ent_t         ent [DEPTH];
    irq_ent_t         up  [DEPTH];
    logic [DEPTH-1:0] hit;
    logic [IDX_W-1:0] hit_idx;
    logic [CNT_W-1:0] cnt;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        assign hit[gi] = ent[gi].valid && (ent[gi].id == pop_id);
        if (gi < DEPTH - 1) begin : g_up
            assign up[gi] = ent[gi+1];
        end else begin : g_last
            assign up[gi] = '0;
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) hit_idx = IDX_W'(i);
        end
    end

    assign pop_hit = |hit;
    assign full    = (cnt == CNT_W'(DEPTH));

    always_comb begin
        run_prio = PRIO_IDLE;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent[i].valid) run_prio = ent[i].prio;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == cnt) ent[i] <= '{valid: 1'b1, id: push_id, prio: push_prio};
            end
            cnt <= cnt + CNT_W'(1);
        end else if (pop_req && pop_hit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= int'(hit_idx)) ent[i] <= up[i];
            end
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
    import cpu_irq_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              act_set,
    output logic [ID_W-1:0]   act_set_id,
    output logic              act_clr,
    output logic [ID_W-1:0]   act_clr_id
);

    logic              ctrl_en;
    logic [PRIO_W-1:0] pmask;
    logic              ack_rd;
    logic              eoi_wr;
    logic [ID_W-1:0]   eoi_id;
    logic [PRIO_W-1:0] run_prio;
    logic              stk_full;
    logic              stk_hit;
    logic              qualify;
    logic [ID_W-1:0]   sel_id;

    cpu_irq_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ctrl_en(ctrl_en), .pmask(pmask),
        .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_id(eoi_id)
    );

    cpu_irq_select u_sel (
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .ctrl_en(ctrl_en), .pmask(pmask), .run_prio(run_prio), .stk_full(stk_full),
        .qualify(qualify), .sel_id(sel_id)
    );

    cpu_irq_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk(clk), .rst(rst),
        .push(ack_rd && qualify), .push_id(cand_id), .push_prio(cand_prio),
        .pop_req(eoi_wr), .pop_id(eoi_id),
        .run_prio(run_prio), .full(stk_full), .pop_hit(stk_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            act_set    <= 1'b0;
            act_set_id <= '0;
            act_clr    <= 1'b0;
            act_clr_id <= '0;
        end else begin
            irq        <= qualify;
            act_set    <= ack_rd && qualify;
            act_set_id <= sel_id;
            act_clr    <= eoi_wr && stk_hit;
            act_clr_id <= eoi_id;
        end
    end

    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, ctrl_en};
            REG_MASK: bus_rdata = {{(DATA_W-PRIO_W){1'b0}}, pmask};
            REG_ACK:  bus_rdata = widen_id(sel_id);
            REG_RUN:  bus_rdata = {{(DATA_W-PRIO_W){1'b0}}, run_prio};
            REG_PEND: bus_rdata = widen_id(sel_id);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpu_irq_port_chk.sv
module cpu_irq_port_chk
    import cpu_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctrl_en,
    input logic              irq,
    input logic [PRIO_W-1:0] cand_prio,
    input logic [PRIO_W-1:0] pmask,
    input logic [PRIO_W-1:0] run_prio,
    input logic              act_set,
    input logic [ID_W-1:0]   act_set_id,
    input logic              act_clr
);

    AST_IRQ_GATED_BY_EN: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> !irq);                                                // R4

    AST_ACK_BELOW_MASK: assert property (@(posedge clk) disable iff (rst)
        act_set |-> ($past(cand_prio) < $past(pmask)));                    // R3

    AST_ACK_PREEMPTS: assert property (@(posedge clk) disable iff (rst)
        act_set |-> ($past(cand_prio) < $past(run_prio)));                 // R5

    AST_RUN_TAKES_ACK: assert property (@(posedge clk) disable iff (rst)
        act_set |-> (run_prio == $past(cand_prio)));                       // R2

    AST_ACK_ID_USABLE: assert property (@(posedge clk) disable iff (rst)
        act_set |-> (act_set_id <= ID_LAST_USE));                          // R8

    AST_RUN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!act_set && !act_clr) |=> $stable(run_prio) || act_set || act_clr); // R7

endmodule

bind cpu_irq_port cpu_irq_port_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .irq(irq), .cand_prio(cand_prio),
    .pmask(pmask), .run_prio(run_prio), .act_set(act_set),
    .act_set_id(act_set_id), .act_clr(act_clr)
);

// File: tb/tb_cpu_irq_port.sv
`timescale 1ns/1ps
module tb_cpu_irq_port;
    import cpu_irq_pkg::*;

    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cand_valid = 1'b0;
    logic [ID_W-1:0]   cand_id = '0;
    logic [PRIO_W-1:0] cand_prio = '1;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq, act_set, act_clr;
    logic [ID_W-1:0]   act_set_id, act_clr_id;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpu_irq_port #(.STACK_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .act_set(act_set), .act_set_id(act_set_id),
        .act_clr(act_clr), .act_clr_id(act_clr_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic set_cand(input logic v, input logic [ID_W-1:0] id, input logic [PRIO_W-1:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p;
    endtask

    task automatic run_is(input string req, input logic [PRIO_W-1:0] exp);
        logic [DATA_W-1:0] d;
        bus_read(3'd4, d);
        chk(req, d, {24'h0, exp});
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        chk("R1 irq after reset", irq, 0);
        bus_read(3'd0, d); chk("R1 R11 ctrl after reset", d, 0);
        bus_read(3'd1, d); chk("R1 R11 mask after reset", d, 0);
        run_is("R1 running after reset", 8'hFF);
    endtask

    task automatic t_disabled();
        logic [DATA_W-1:0] d;
        bus_write(3'd1, 32'hF0);
        set_cand(1'b1, 10'd40, 8'h10);
        @(negedge clk); @(negedge clk);
        chk("R4 irq low while disabled", irq, 0);
        bus_read(3'd2, d); chk("R4 ack spurious while disabled", d, 1023);
        chk("R4 no act_set while disabled", act_set, 0);
        run_is("R4 running unchanged", 8'hFF);
    endtask

    task automatic t_basic();
        logic [DATA_W-1:0] d;
        set_cand(1'b0, 10'd40, 8'h10);
        bus_write(3'd0, 32'h1);
        @(negedge clk);
        chk("R8 invalid candidate not signalled", irq, 0);
        set_cand(1'b1, 10'd40, 8'h10);
        #5 chk("R10 irq not yet risen", irq, 0);
        @(negedge clk);
        chk("R10 R3 irq rises one cycle later (A0-style pass)", irq, 1);
        bus_read(3'd5, d); chk("R11 pending read id", d, 40);
        run_is("R11 pending read has no side effect", 8'hFF);
        bus_read(3'd2, d); chk("R2 ack returns id", d, 40);
        chk("R2 act_set pulse", act_set, 1);
        chk("R2 act_set_id", act_set_id, 40);
        @(negedge clk);
        chk("R2 act_set one cycle", act_set, 0);
        chk("R10 irq falls after ack", irq, 0);
        run_is("R2 running takes priority", 8'h10);
        bus_read(3'd2, d); chk("R5 equal priority not acked", d, 1023);
    endtask

    task automatic t_preempt_eoi();
        logic [DATA_W-1:0] d;
        set_cand(1'b1, 10'd50, 8'h08);
        @(negedge clk);
        chk("R5 more urgent signalled", irq, 1);
        bus_read(3'd2, d); chk("R5 preempt ack id", d, 50);
        run_is("R5 running after preempt", 8'h08);
        set_cand(1'b0, 10'd0, 8'hFF);
        bus_write(3'd3, 32'd77);
        chk("R7 no act_clr for inactive id", act_clr, 0);
        run_is("R7 running unchanged", 8'h08);
        bus_write(3'd3, 32'd40);
        chk("R12 act_clr for inner id", act_clr, 1);
        chk("R12 act_clr_id", act_clr_id, 40);
        run_is("R12 running unchanged", 8'h08);
        bus_write(3'd3, 32'd40);
        chk("R7 repeated eoi ignored", act_clr, 0);
        bus_write(3'd3, 32'd50);
        chk("R6 act_clr top id", act_clr_id, 50);
        run_is("R6 running back to idle", 8'hFF);
    endtask

    task automatic t_mask();
        logic [DATA_W-1:0] d;
        bus_write(3'd1, 32'hA0);
        set_cand(1'b1, 10'd60, 8'hA0);
        @(negedge clk); @(negedge clk);
        chk("R3 equal to mask not signalled", irq, 0);
        bus_read(3'd2, d); chk("R3 equal to mask not acked", d, 1023);
        set_cand(1'b1, 10'd61, 8'h9F);
        @(negedge clk);
        chk("R3 below mask signalled", irq, 1);
        bus_read(3'd2, d); chk("R3 below mask acked", d, 61);
        bus_write(3'd3, 32'd61);
        run_is("R6 idle after eoi", 8'hFF);
        bus_write(3'd1, 32'hF0);
    endtask

    task automatic t_reserved();
        logic [DATA_W-1:0] d;
        set_cand(1'b1, 10'd1020, 8'h01);
        @(negedge clk); @(negedge clk);
        chk("R8 reserved id not signalled", irq, 0);
        bus_read(3'd2, d); chk("R8 reserved id spurious", d, 1023);
        set_cand(1'b1, 10'd1019, 8'h01);
        @(negedge clk);
        chk("R8 id 1019 signalled", irq, 1);
        set_cand(1'b0, 10'd1019, 8'h01);
        @(negedge clk);
        bus_read(3'd2, d); chk("R8 invalid flag spurious", d, 1023);
    endtask

    task automatic t_full();
        logic [DATA_W-1:0] d;
        for (int k = 0; k < DEPTH; k++) begin
            set_cand(1'b1, 10'(100 + k), 8'(8'h40 - 8'h10 * k));
            bus_read(3'd2, d); chk("R2 fill ack", d, 32'(100 + k));
        end
        set_cand(1'b1, 10'd200, 8'h01);
        @(negedge clk); @(negedge clk);
        chk("R9 full stack no irq", irq, 0);
        bus_read(3'd2, d); chk("R9 full stack spurious", d, 1023);
        set_cand(1'b0, 10'd0, 8'hFF);
        bus_write(3'd3, 32'(100 + DEPTH - 1));
        run_is("R6 previous stacked priority", 8'(8'h40 - 8'h10 * (DEPTH - 2)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_basic();
        t_preempt_eoi();
        t_mask();
        t_reserved();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule